// File: doc/BRIEF.md
# RGB to CMYK Pixel Converter

This block turns one RGB pixel into the four ink amounts a printer needs. Each of red, green and blue is an 8-bit unsigned value. The block first forms the complementary cyan, magenta and yellow amounts by subtracting each channel from full scale. It then takes the smallest of those three as the shared gray part and sends it out as the black channel. Last, it subtracts that black amount from each of the three colour inks.

The datapath uses only subtractors, magnitude comparators and 2:1 multiplexers. The minimum comes from two two-input minimum cells placed in series. A parameter decides how the result leaves the block. When the parameter is set, an output register loads on an input-valid strobe and raises the output-valid flag one cycle later. When it is clear, the outputs follow the inputs with no clock, and the valid flag is the input strobe itself.

Top module: `rgb2cmyk_conv`

## Requirements
- R1: `out_black` equals the smallest of 255−R, 255−G and 255−B, which is 255 minus the largest input channel.
- R2: `out_cyan`, `out_magenta` and `out_yellow` equal 255−R, 255−G and 255−B, each reduced by the black value of R1.
- R3: For every valid pixel, at least one of the cyan, magenta and yellow outputs is zero. No output wraps below zero.
- R4: A white pixel (255,255,255) gives all four outputs zero.
- R5: A black pixel (0,0,0) gives black 255 and zero cyan, magenta and yellow.
- R6: The pixel (5,55,55) has complements (250,200,200). It gives cyan 50, magenta 0, yellow 0 and black 200.
- R7: With `OUT_REG`=1, a pixel presented with `in_valid` high at a rising edge shows up on the four outputs after that edge, and `out_valid` is high in the same cycle.
- R8: With `OUT_REG`=1, a rising edge with `in_valid` low leaves all four outputs unchanged, even when the input channels change, and drives `out_valid` low.
- R9: With `OUT_REG`=1, a rising edge with `rst` high clears all four outputs and `out_valid` to zero.
- R10: With `OUT_REG`=0, the outputs follow the inputs with no clock edge, and `out_valid` equals `in_valid`.
- R11: When two or three complements tie for the smallest value, black is that shared value and every tied channel comes out as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel strobe |
| in_red | input | 8 | Red channel, unsigned |
| in_green | input | 8 | Green channel, unsigned |
| in_blue | input | 8 | Blue channel, unsigned |
| out_cyan | output | 8 | Cyan ink after black removal |
| out_magenta | output | 8 | Magenta ink after black removal |
| out_yellow | output | 8 | Yellow ink after black removal |
| out_black | output | 8 | Black ink, the shared gray part |
| out_valid | output | 1 | Result valid flag |

## Verification
The bench builds two copies side by side. One has `OUT_REG`=1, so the registered timing, the hold on a low strobe and the clearing by reset can be reached. The other has `OUT_REG`=0, so the combinational path can be sampled within the same cycle in which its input is driven. The channel width is a package constant left at 8 bits. Every pixel therefore reaches the true extremes 0 and 255, which exposes any underflow or off-by-one in the complement. The chosen pixels place the minimum on each of the three channels in turn and include two-way and three-way ties.

// File: rtl/rgb2cmyk_pkg.sv
package rgb2cmyk_pkg;

    localparam int CHAN_W = 8;
    localparam int NUM_CH = 3;
    localparam logic [CHAN_W-1:0] CHAN_MAX = '1;

    typedef logic [CHAN_W-1:0] chan_t;

    // Slot order inside a three-channel bundle
    typedef enum logic [1:0] {
        SLOT_0 = 2'd0,
        SLOT_1 = 2'd1,
        SLOT_2 = 2'd2
    } slot_e;

    typedef chan_t [NUM_CH-1:0] trio_t;

    typedef struct packed {
        chan_t cyan;
        chan_t magenta;
        chan_t yellow;
        chan_t black;
    } ink_t;

    function automatic chan_t chan_max3(chan_t a, chan_t b, chan_t c);
        chan_t t;
        t = (a >= b) ? a : b;
        return (t >= c) ? t : c;
    endfunction

endpackage

// File: rtl/cmyk_complement.sv
module cmyk_complement
    import rgb2cmyk_pkg::*;
(
    input  trio_t light,
    output trio_t ink
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign ink[i] = CHAN_MAX - light[i];
    end
endmodule

// File: rtl/cmyk_min2.sv
module cmyk_min2
    import rgb2cmyk_pkg::*;
(
    input  chan_t lhs,
    input  chan_t rhs,
    output chan_t least
);
    logic lhs_le;
    assign lhs_le = (lhs <= rhs);
    assign least  = lhs_le ? lhs : rhs;
endmodule

// File: rtl/cmyk_gray_strip.sv
module cmyk_gray_strip
    import rgb2cmyk_pkg::*;
(
    input  trio_t full,
    input  chan_t gray,
    output trio_t rest
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign rest[i] = full[i] - gray;
    end
endmodule

// File: rtl/rgb2cmyk_conv.sv
module rgb2cmyk_conv
    import rgb2cmyk_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [CHAN_W-1:0]     in_red,
    input  logic [CHAN_W-1:0]     in_green,
    input  logic [CHAN_W-1:0]     in_blue,
    output logic [CHAN_W-1:0]     out_cyan,
    output logic [CHAN_W-1:0]     out_magenta,
    output logic [CHAN_W-1:0]     out_yellow,
    output logic [CHAN_W-1:0]     out_black,
    output logic                  out_valid
);
    trio_t light;
    trio_t comp;
    trio_t rest;
    chan_t pair_min;
    chan_t gray;
    ink_t  res_d;
    ink_t  res_q;
    logic  vld_q;

    assign light[SLOT_0] = in_red;
    assign light[SLOT_1] = in_green;
    assign light[SLOT_2] = in_blue;

    cmyk_complement u_comp (
        .light (light),
        .ink   (comp)
    );

    cmyk_min2 u_min_a (
        .lhs   (comp[SLOT_0]),
        .rhs   (comp[SLOT_1]),
        .least (pair_min)
    );

    cmyk_min2 u_min_b (
        .lhs   (pair_min),
        .rhs   (comp[SLOT_2]),
        .least (gray)
    );

    cmyk_gray_strip u_strip (
        .full (comp),
        .gray (gray),
        .rest (rest)
    );

    assign res_d.cyan    = rest[SLOT_0];
    assign res_d.magenta = rest[SLOT_1];
    assign res_d.yellow  = rest[SLOT_2];
    assign res_d.black   = gray;

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                res_q <= '0;
                vld_q <= 1'b0;
            end else begin
                vld_q <= in_valid;
                if (in_valid) begin
                    res_q <= res_d;
                end
            end
        end
    end else begin : g_comb
        assign res_q = res_d;
        assign vld_q = in_valid;
    end

    assign out_cyan    = res_q.cyan;
    assign out_magenta = res_q.magenta;
    assign out_yellow  = res_q.yellow;
    assign out_black   = res_q.black;
    assign out_valid   = vld_q;
endmodule

// File: rtl/rgb2cmyk_chk.sv
module rgb2cmyk_chk
    import rgb2cmyk_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic  clk,
    input logic  rst,
    input logic  in_valid,
    input chan_t in_red,
    input chan_t in_green,
    input chan_t in_blue,
    input chan_t out_cyan,
    input chan_t out_magenta,
    input chan_t out_yellow,
    input chan_t out_black,
    input logic  out_valid
);
    // R3
    one_ink_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_cyan == '0 || out_magenta == '0 || out_yellow == '0));

    if (OUT_REG) begin : g_reg
        // R1
        black_value_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> (out_black ==
                CHAN_MAX - chan_max3($past(in_red), $past(in_green), $past(in_blue))));

        // R7
        valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);

        // R8
        hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> (!out_valid && $stable(out_cyan) && $stable(out_magenta)
                           && $stable(out_yellow) && $stable(out_black)));

        // R9
        reset_clear_chk: assert property (@(posedge clk)
            rst |=> (!out_valid && out_cyan == '0 && out_magenta == '0
                     && out_yellow == '0 && out_black == '0));
    end else begin : g_comb
        // R1
        black_value_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |-> (out_black == CHAN_MAX - chan_max3(in_red, in_green, in_blue)));

        // R10
        valid_pass_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid == in_valid);
    end
endmodule

bind rgb2cmyk_conv rgb2cmyk_chk #(.OUT_REG(OUT_REG)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_red      (in_red),
    .in_green    (in_green),
    .in_blue     (in_blue),
    .out_cyan    (out_cyan),
    .out_magenta (out_magenta),
    .out_yellow  (out_yellow),
    .out_black   (out_black),
    .out_valid   (out_valid)
);

// File: tb/rgb2cmyk_conv_tb.sv
`timescale 1ns/1ps
module rgb2cmyk_conv_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_red = '0, in_green = '0, in_blue = '0;
    logic [7:0] r_c, r_m, r_y, r_k, c_c, c_m, c_y, c_k;
    logic       r_v, c_v;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rgb2cmyk_conv #(.OUT_REG(1'b1)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_red(in_red), .in_green(in_green), .in_blue(in_blue),
        .out_cyan(r_c), .out_magenta(r_m), .out_yellow(r_y), .out_black(r_k),
        .out_valid(r_v)
    );

    rgb2cmyk_conv #(.OUT_REG(1'b0)) dut_comb_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_red(in_red), .in_green(in_green), .in_blue(in_blue),
        .out_cyan(c_c), .out_magenta(c_m), .out_yellow(c_y), .out_black(c_k),
        .out_valid(c_v)
    );

    // {red, green, blue, cyan, magenta, yellow, black}
    localparam logic [55:0] VECS [12] = '{
        {8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd255},
        {8'd255, 8'd255, 8'd255, 8'd0,   8'd0,   8'd0,   8'd0},
        {8'd5,   8'd55,  8'd55,  8'd50,  8'd0,   8'd0,   8'd200},
        {8'd255, 8'd0,   8'd0,   8'd0,   8'd255, 8'd255, 8'd0},
        {8'd0,   8'd255, 8'd0,   8'd255, 8'd0,   8'd255, 8'd0},
        {8'd0,   8'd0,   8'd255, 8'd255, 8'd255, 8'd0,   8'd0},
        {8'd63,  8'd0,   8'd15,  8'd0,   8'd63,  8'd48,  8'd192},
        {8'd100, 8'd100, 8'd200, 8'd100, 8'd100, 8'd0,   8'd55},
        {8'd10,  8'd200, 8'd200, 8'd190, 8'd0,   8'd0,   8'd55},
        {8'd128, 8'd64,  8'd32,  8'd0,   8'd64,  8'd96,  8'd127},
        {8'd1,   8'd254, 8'd1,   8'd253, 8'd0,   8'd253, 8'd1},
        {8'd77,  8'd77,  8'd77,  8'd0,   8'd0,   8'd0,   8'd178}
    };

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic [7:0] c, m, y, k, input logic [7:0] ec, em, ey, ek);
        chk(tag, "cyan", c, ec);
        chk(tag, "magenta", m, em);
        chk(tag, "yellow", y, ey);
        chk(tag, "black", k, ek);
    endtask

    // Drive at negedge, check combinational copy, then registered copy one edge later
    task automatic run_pixel(input string tag, input logic [7:0] r, g, b, ec, em, ey, ek);
        @(negedge clk);
        in_red = r; in_green = g; in_blue = b; in_valid = 1'b1;
        #2;
        chk_all({tag, " R10 comb"}, c_c, c_m, c_y, c_k, ec, em, ey, ek);
        chk({tag, " R10 comb"}, "valid", {7'd0, c_v}, 8'd1);
        @(posedge clk);
        @(negedge clk);
        chk_all({tag, " R7 reg"}, r_c, r_m, r_y, r_k, ec, em, ey, ek);
        chk({tag, " R7 reg"}, "valid", {7'd0, r_v}, 8'd1);
        // R3: one ink zero
        chk({tag, " R3"}, "zero-ink", {7'd0, (r_c == 0 || r_m == 0 || r_y == 0)}, 8'd1);
    endtask

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_all("R9 reset", r_c, r_m, r_y, r_k, 8'd0, 8'd0, 8'd0, 8'd0);
        chk("R9 reset", "valid", {7'd0, r_v}, 8'd0);
        rst = 1'b0;

        // R1 R2 table walk
        for (int i = 0; i < 12; i++) begin
            run_pixel("R1 R2", VECS[i][55:48], VECS[i][47:40], VECS[i][39:32],
                      VECS[i][31:24], VECS[i][23:16], VECS[i][15:8], VECS[i][7:0]);
        end

        // Directed corners
        run_pixel("R4", 8'd255, 8'd255, 8'd255, 8'd0, 8'd0, 8'd0, 8'd0);
        run_pixel("R5", 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd255);
        run_pixel("R6", 8'd5, 8'd55, 8'd55, 8'd50, 8'd0, 8'd0, 8'd200);
        run_pixel("R11", 8'd90, 8'd90, 8'd20, 8'd0, 8'd0, 8'd70, 8'd165);
        run_pixel("R11", 8'd40, 8'd200, 8'd200, 8'd160, 8'd0, 8'd0, 8'd55);

        // R8: strobe low, inputs change, registered outputs hold
        @(negedge clk);
        in_valid = 1'b0; in_red = 8'd7; in_green = 8'd9; in_blue = 8'd11;
        #2;
        chk("R10 idle", "valid", {7'd0, c_v}, 8'd0);
        @(posedge clk);
        @(negedge clk);
        chk_all("R8 hold", r_c, r_m, r_y, r_k, 8'd160, 8'd0, 8'd0, 8'd55);
        chk("R8 hold", "valid", {7'd0, r_v}, 8'd0);

        // R9: reset during a valid pixel
        run_pixel("R7", 8'd128, 8'd64, 8'd32, 8'd0, 8'd64, 8'd96, 8'd127);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_all("R9 mid", r_c, r_m, r_y, r_k, 8'd0, 8'd0, 8'd0, 8'd0);
        chk("R9 mid", "valid", {7'd0, r_v}, 8'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule